// File: doc/BRIEF.md
# Configuration Mechanism One Host Port

This block sits on the host I/O space and turns the two-register configuration access method into configuration transactions. Software first writes a 32-bit selector (enable, bus, device, function, register) to the address port at I/O address 0x0CF8. A later read or write to the data window at I/O address 0x0CFC then launches one configuration transaction toward the downstream request interface. The block holds the host access until the completion returns.

The encoding of the transaction address depends on the bus number in the selector. Bus zero gives a Type 0 cycle, where the device number becomes a single set bit counted upward from address bit 11. Any other bus gives a Type 1 cycle that carries bus, device, function and register as binary fields. Selectors that cannot be encoded, or that have the enable bit clear, finish locally with no transaction.

Top module: `cm1_port`

## Requirements
- R1: After a synchronous active-low reset the selector register reads zero, `io_ready` is low and `cfg_req` is low.
- R2: A write to the address port (io_addr[15:2] equal to 0x0CF8>>2) updates only the byte lanes whose `io_be` bit is set; bits 30:24 and 1:0 always read zero; a read of the address port raises `io_ready` one cycle after the strobe with the selector on `io_rdata`.
- R3: With selector bit 31 clear, a data-port access raises no `cfg_req`, raises `io_ready` one cycle after the strobe, and a read returns 0xFFFFFFFF.
- R4: With the enable set and bus (selector bits 23:16) zero, `cfg_type1` is 0 and `cfg_addr` has exactly one bit set among bits 31:11, namely bit 11+device (device from selector bits 15:11), function (selector 10:8) in bits 10:8, register (selector 7:2) in bits 7:2, and 00 in bits 1:0.
- R5: With the enable set and a nonzero bus, `cfg_type1` is 1 and `cfg_addr` holds zero in 31:24, bus in 23:16, device in 15:11, function in 10:8, register in 7:2 and 01 in 1:0.
- R6: A Type 0 selector with device number above 20 raises no `cfg_req`; it completes one cycle after the strobe, and a read returns 0xFFFFFFFF.
- R7: A launched transaction carries the byte enables of the data-port access unchanged on `cfg_be`, `cfg_we` equal to 1 for a write and 0 for a read, and the write data on `cfg_wdata`; any address within 0x0CFC..0x0CFF hits the data port.
- R8: After a launch, `io_ready` stays low until `cfg_done` is sampled high; `io_ready` rises in the next cycle with `io_rdata` equal to the `cfg_rdata` sampled with `cfg_done`.
- R9: `cfg_req` is high for exactly one cycle per transaction and appears one cycle after the accepted strobe; host strobes that arrive while a transaction is outstanding are dropped and leave the selector unchanged.
- R10: Strobes to I/O addresses outside 0x0CF8..0x0CFF give no `io_ready`, no `cfg_req` and no change to the selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_be | input | 4 | Host byte enables |
| io_wdata | input | 32 | Host write data |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_ready | output | 1 | Access complete, one-cycle pulse |
| io_rdata | output | 32 | Read data, valid with io_ready |
| cfg_req | output | 1 | Configuration transaction request, one-cycle pulse |
| cfg_addr | output | 32 | Encoded configuration address |
| cfg_type1 | output | 1 | 1 for Type 1, 0 for Type 0 |
| cfg_be | output | 4 | Transaction byte enables |
| cfg_we | output | 1 | 1 for write transaction |
| cfg_wdata | output | 32 | Transaction write data |
| cfg_done | input | 1 | Transaction completion |
| cfg_rdata | input | 32 | Completion read data |

## Verification
On every cycle the assertions check the shape of each launched address (one select bit and 00 for Type 0, clear top byte and 01 for Type 1), that requests are single-cycle pulses tied to a preceding host strobe with its byte enables and direction, and that the host sees no completion while a request is outstanding and sees the completion data right after it. Whether a given selector ought to launch at all (enable clear, device above 20), the exact field values, byte-lane masking of the selector, dropping of strobes while busy and of foreign addresses can only be shown by the bench's scenarios against its reference model.

// File: rtl/cm1_pkg.sv
// Shared constants and types for the configuration mechanism one port.
// Assumes a 32-bit configuration address and a 16-bit host I/O space.
package cm1_pkg;
    localparam int CFG_AW     = 32;
    localparam int SEL_LSB    = 11;
    localparam int MAX_T0_DEV = CFG_AW - SEL_LSB - 1;
    localparam logic [CFG_AW-1:0] SEL_WMASK = 32'h80FF_FFFC;

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ctl_state_t;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] regno;
    } cfg_sel_t;

    // Split the stored selector word into its fields.
    function automatic cfg_sel_t sel_from_word(input logic [CFG_AW-1:0] w);
        cfg_sel_t s;
        s.en    = w[31];
        s.bus   = w[23:16];
        s.dev   = w[15:11];
        s.fn    = w[10:8];
        s.regno = w[7:2];
        return s;
    endfunction
endpackage

// File: rtl/cm1_addr_reg.sv
// Selector register behind the address port.
// Byte-lane writes; bits outside WMASK are held at zero.
// Assumes DW is a multiple of 8.
module cm1_addr_reg #(
    parameter int DW = 32,
    parameter logic [DW-1:0] WMASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW/8-1:0] be,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   value
);
    localparam int NB = DW / 8;

    logic [7:0] lane_q [NB];

    genvar b;
    generate
        for (b = 0; b < NB; b++) begin : g_lane
            // Update one byte lane when its enable is set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q[b] <= '0;
                end else if (wr_en && be[b]) begin
                    lane_q[b] <= wdata[b*8 +: 8] & WMASK[b*8 +: 8];
                end
            end
            assign value[b*8 +: 8] = lane_q[b];
        end
    endgenerate
endmodule

// File: rtl/cm1_encode.sv
// Combinational configuration address encoder.
// Type 0 for bus zero with one select bit per device from SEL_LSB,
// Type 1 otherwise. dev_ok is low when a Type 0 device has no select bit.
module cm1_encode
    import cm1_pkg::*;
(
    input  logic [7:0]        bus,
    input  logic [4:0]        dev,
    input  logic [2:0]        fn,
    input  logic [5:0]        regno,
    output logic [CFG_AW-1:0] addr,
    output logic              type1,
    output logic              dev_ok
);
    logic [MAX_T0_DEV:0] dev_hot;
    logic [CFG_AW-1:0]   t0_addr;
    logic [CFG_AW-1:0]   t1_addr;

    genvar g;
    generate
        for (g = 0; g <= MAX_T0_DEV; g++) begin : g_sel
            assign dev_hot[g] = (dev == 5'(g));
        end
    endgenerate

    // Build both encodings and pick one by bus number.
    always_comb begin
        t0_addr                  = '0;
        t0_addr[CFG_AW-1:SEL_LSB] = dev_hot;
        t0_addr[10:8]            = fn;
        t0_addr[7:2]             = regno;
        t1_addr                  = {8'h00, bus, dev, fn, regno, 2'b01};
        type1                    = (bus != 8'h00);
        dev_ok                   = type1 | (|dev_hot);
        addr                     = type1 ? t1_addr : t0_addr;
    end
endmodule

// File: rtl/cm1_ctrl.sv
// Access sequencer: accepts host strobes when idle, answers the address
// port locally, launches one configuration transaction per valid data
// access and holds the host until the completion. Strobes while waiting
// are dropped. Outputs are registered.
module cm1_ctrl
    import cm1_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit_addr,
    input  logic            hit_data,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [DW/8-1:0] io_be,
    input  logic [DW-1:0]   io_wdata,
    input  logic            port_en,
    input  logic            dev_ok,
    input  logic [CFG_AW-1:0] enc_addr,
    input  logic            enc_type1,
    input  logic [DW-1:0]   sel_word,
    input  logic            cfg_done,
    input  logic [DW-1:0]   cfg_rdata,
    output logic            addr_wr,
    output logic            io_ready,
    output logic [DW-1:0]   io_rdata,
    output logic            cfg_req,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic            cfg_type1,
    output logic [DW/8-1:0] cfg_be,
    output logic            cfg_we,
    output logic [DW-1:0]   cfg_wdata
);
    ctl_state_t state_q;
    logic       access;
    logic       launch;

    // Classify the current strobe.
    always_comb begin
        access  = (io_rd | io_wr) && (state_q == ST_IDLE);
        addr_wr = access && hit_addr && io_wr;
        launch  = access && hit_data && port_en && dev_ok;
    end

    // Sequence accesses and register every host and request output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            io_ready  <= 1'b0;
            io_rdata  <= '0;
            cfg_req   <= 1'b0;
            cfg_addr  <= '0;
            cfg_type1 <= 1'b0;
            cfg_be    <= '0;
            cfg_we    <= 1'b0;
            cfg_wdata <= '0;
        end else begin
            io_ready <= 1'b0;
            cfg_req  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        cfg_req   <= 1'b1;
                        cfg_addr  <= enc_addr;
                        cfg_type1 <= enc_type1;
                        cfg_be    <= io_be;
                        cfg_we    <= io_wr;
                        cfg_wdata <= io_wdata;
                        state_q   <= ST_WAIT;
                    end else if (access && hit_addr) begin
                        io_ready <= 1'b1;
                        io_rdata <= sel_word;
                    end else if (access && hit_data) begin
                        io_ready <= 1'b1;
                        io_rdata <= '1;
                    end
                end
                ST_WAIT: begin
                    if (cfg_done) begin
                        io_ready <= 1'b1;
                        io_rdata <= cfg_rdata;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cm1_port.sv
// Top of the configuration mechanism one host port.
// Decodes the address port and the data window in host I/O space,
// stores the selector, encodes it and sequences transactions.
// Assumes single-cycle host strobes and one completion per request.
module cm1_port
    import cm1_pkg::*;
#(
    parameter int IO_AW = 16,
    parameter int DW = 32,
    parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
    parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [DW/8-1:0] io_be,
    input  logic [DW-1:0]   io_wdata,
    input  logic            io_rd,
    input  logic            io_wr,
    output logic            io_ready,
    output logic [DW-1:0]   io_rdata,
    output logic            cfg_req,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic            cfg_type1,
    output logic [DW/8-1:0] cfg_be,
    output logic            cfg_we,
    output logic [DW-1:0]   cfg_wdata,
    input  logic            cfg_done,
    input  logic [DW-1:0]   cfg_rdata
);
    logic            hit_addr;
    logic            hit_data;
    logic            addr_wr;
    logic [DW-1:0]   sel_word;
    cfg_sel_t        sel;
    logic [CFG_AW-1:0] enc_addr;
    logic            enc_type1;
    logic            dev_ok;
    logic            unused_lsb;

    // Decode the two dword-aligned ports.
    always_comb begin
        hit_addr   = (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
        hit_data   = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
        sel        = sel_from_word(sel_word);
        unused_lsb = ^io_addr[1:0];
    end

    cm1_addr_reg #(.DW(DW), .WMASK(SEL_WMASK)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (addr_wr),
        .be    (io_be),
        .wdata (io_wdata),
        .value (sel_word)
    );

    cm1_encode u_enc (
        .bus    (sel.bus),
        .dev    (sel.dev),
        .fn     (sel.fn),
        .regno  (sel.regno),
        .addr   (enc_addr),
        .type1  (enc_type1),
        .dev_ok (dev_ok)
    );

    cm1_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .io_be     (io_be),
        .io_wdata  (io_wdata),
        .port_en   (sel.en),
        .dev_ok    (dev_ok),
        .enc_addr  (enc_addr),
        .enc_type1 (enc_type1),
        .sel_word  (sel_word),
        .cfg_done  (cfg_done),
        .cfg_rdata (cfg_rdata),
        .addr_wr   (addr_wr),
        .io_ready  (io_ready),
        .io_rdata  (io_rdata),
        .cfg_req   (cfg_req),
        .cfg_addr  (cfg_addr),
        .cfg_type1 (cfg_type1),
        .cfg_be    (cfg_be),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata)
    );
endmodule

// File: rtl/cm1_port_chk.sv
// Property checker for cm1_port, attached by bind below.
// Tracks outstanding requests on its own from the port signals.
module cm1_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_rd,
    input logic        io_wr,
    input logic [3:0]  io_be,
    input logic        io_ready,
    input logic [31:0] io_rdata,
    input logic        cfg_req,
    input logic [31:0] cfg_addr,
    input logic        cfg_type1,
    input logic [3:0]  cfg_be,
    input logic        cfg_we,
    input logic        cfg_done,
    input logic [31:0] cfg_rdata
);
    logic pend_q;

    // Remember a request until its completion is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else if (cfg_done) pend_q <= 1'b0;
        else if (cfg_req) pend_q <= 1'b1;
    end

    a_r4_type0_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_type1) |-> ($countones(cfg_addr[31:11]) == 1 && cfg_addr[1:0] == 2'b00));

    a_r5_type1_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_type1) |-> (cfg_addr[31:24] == 8'h00 && cfg_addr[1:0] == 2'b01));

    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> !cfg_req);

    a_r9_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> $past(io_rd || io_wr));

    a_r7_be_dir: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_be == $past(io_be) && cfg_we == $past(io_wr)));

    a_r8_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_req || pend_q) && !cfg_done) |=> !io_ready);

    a_r8_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_req || pend_q) && cfg_done) |=> (io_ready && io_rdata == $past(cfg_rdata)));
endmodule

bind cm1_port cm1_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_be     (io_be),
    .io_ready  (io_ready),
    .io_rdata  (io_rdata),
    .cfg_req   (cfg_req),
    .cfg_addr  (cfg_addr),
    .cfg_type1 (cfg_type1),
    .cfg_be    (cfg_be),
    .cfg_we    (cfg_we),
    .cfg_done  (cfg_done),
    .cfg_rdata (cfg_rdata)
);

// File: tb/cm1_port_tb.sv
module cm1_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        io_ready;
    logic [31:0] io_rdata;
    logic        cfg_req;
    logic [31:0] cfg_addr;
    logic        cfg_type1;
    logic [3:0]  cfg_be;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic        cfg_done = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] m_sel = '0;
    bit          exp_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cm1_port u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_be(io_be),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .io_ready(io_ready), .io_rdata(io_rdata), .cfg_req(cfg_req),
        .cfg_addr(cfg_addr), .cfg_type1(cfg_type1), .cfg_be(cfg_be),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_done(cfg_done),
        .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the request strobe with the model (R9).
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) chk(cfg_req === exp_req, "R9 cfg_req per-cycle", 32'(cfg_req), 32'(exp_req));
    end

    function automatic bit m_go(input logic [31:0] s);
        return s[31] && (s[23:16] != 0 || s[15:11] <= 20);
    endfunction

    function automatic logic [31:0] m_addr(input logic [31:0] s);
        int bus = s[23:16];
        int dev = s[15:11];
        int fn  = s[10:8];
        int rg  = s[7:2];
        if (bus == 0) return 32'((64'd1 << (11 + dev)) | (fn << 8) | (rg << 2));
        return 32'((bus << 16) | (dev << 11) | (fn << 8) | (rg << 2) | 1);
    endfunction

    // Access at the address port or a foreign address.
    task automatic aport(input bit is_wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string tag);
        bit hit = (a[15:2] == 14'h033E);
        io_addr = a; io_be = be; io_wdata = d; io_wr = is_wr; io_rd = !is_wr;
        @(posedge clk);
        @(negedge clk);
        io_wr = 0; io_rd = 0;
        chk(io_ready === hit, {tag, " ready"}, 32'(io_ready), 32'(hit));
        if (hit && !is_wr) chk(io_rdata === m_sel, {tag, " readback"}, io_rdata, m_sel);
        if (hit && is_wr)
            for (int b = 0; b < 4; b++)
                if (be[b]) m_sel[b*8 +: 8] = d[b*8 +: 8] & (32'h80FF_FFFC >> (b*8));
    endtask

    // Access at the data window with a completion after dly cycles.
    task automatic dport(input bit is_wr, input logic [15:0] a, input logic [3:0] be,
                         input logic [31:0] d, input int dly, input logic [31:0] rsp,
                         input bit poke, input string tag);
        bit go = m_go(m_sel);
        logic [31:0] ea = m_addr(m_sel);
        io_addr = a; io_be = be; io_wdata = d; io_wr = is_wr; io_rd = !is_wr;
        @(posedge clk);
        exp_req = go;
        @(negedge clk);
        io_wr = 0; io_rd = 0;
        if (!go) begin
            chk(io_ready === 1'b1, {tag, " local ready"}, 32'(io_ready), 1);
            if (!is_wr) chk(io_rdata === 32'hFFFF_FFFF, {tag, " all ones"}, io_rdata, 32'hFFFF_FFFF);
        end else begin
            chk(cfg_addr === ea, {tag, " cfg_addr"}, cfg_addr, ea);
            chk(cfg_type1 === (m_sel[23:16] != 0), {tag, " type"}, 32'(cfg_type1), 32'(m_sel[23:16] != 0));
            chk(cfg_be === be, {tag, " R7 be"}, 32'(cfg_be), 32'(be));
            chk(cfg_we === is_wr, {tag, " R7 we"}, 32'(cfg_we), 32'(is_wr));
            if (is_wr) chk(cfg_wdata === d, {tag, " R7 wdata"}, cfg_wdata, d);
            chk(io_ready === 1'b0, {tag, " R8 stall"}, 32'(io_ready), 0);
            exp_req = 0;
            for (int i = 0; i < dly; i++) begin
                if (poke && i == 0) begin
                    io_addr = 16'h0CF8; io_be = 4'hF; io_wdata = 32'h8011_2233; io_wr = 1;
                end
                @(negedge clk);
                io_wr = 0;
                chk(io_ready === 1'b0, {tag, " R8 stall"}, 32'(io_ready), 0);
            end
            cfg_done = 1; cfg_rdata = rsp;
            @(negedge clk);
            cfg_done = 0;
            chk(io_ready === 1'b1, {tag, " R8 ready"}, 32'(io_ready), 1);
            if (!is_wr) chk(io_rdata === rsp, {tag, " R8 rdata"}, io_rdata, rsp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(io_ready === 1'b0, "R1 ready after reset", 32'(io_ready), 0);
        chk(cfg_req === 1'b0, "R1 req after reset", 32'(cfg_req), 0);
        aport(0, 16'h0CF8, 4'hF, 0, "R1 selector zero");
        aport(1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, "R2 full write");
        aport(0, 16'h0CF8, 4'hF, 0, "R2 reserved bits zero");
        aport(1, 16'h0CF8, 4'b0010, 32'h0, "R2 lane write");
        aport(0, 16'h0CF8, 4'hF, 0, "R2 lane readback");
        aport(1, 16'h0CF8, 4'hF, 32'h0000_0810, "R3 setup");
        dport(0, 16'h0CFC, 4'hF, 0, 2, 0, 0, "R3 disabled read");
        aport(1, 16'h0CF8, 4'hF, 32'h8000_1A40, "R4 setup");
        dport(0, 16'h0CFC, 4'hF, 0, 3, 32'h1234_5678, 0, "R4 type0 read");
        aport(1, 16'h0CF8, 4'hF, 32'h8000_A7FC, "R4 setup dev20");
        dport(1, 16'h0CFC, 4'hF, 32'hCAFE_0001, 1, 0, 0, "R4 dev20 write");
        aport(1, 16'h0CF8, 4'hF, 32'h8000_A800, "R6 setup dev21");
        dport(0, 16'h0CFC, 4'hF, 0, 1, 0, 0, "R6 dev21 read");
        aport(1, 16'h0CF8, 4'hF, 32'h8000_F800, "R6 setup dev31");
        dport(1, 16'h0CFC, 4'hF, 32'h1, 1, 0, 0, "R6 dev31 write");
        aport(1, 16'h0CF8, 4'hF, 32'h8005_A904, "R5 setup");
        dport(1, 16'h0CFC, 4'hF, 32'hDEAD_BEEF, 2, 0, 0, "R5 type1 write");
        aport(1, 16'h0CF8, 4'hF, 32'h80FF_FFFC, "R7 setup");
        dport(1, 16'h0CFE, 4'b1100, 32'hAB00_0000, 1, 0, 0, "R7 byte write");
        dport(0, 16'h0CFD, 4'b0010, 0, 0, 32'h0000_5500, 0, "R8 zero-delay read");
        aport(1, 16'h0CF8, 4'hF, 32'h8003_0100, "R9 setup");
        dport(0, 16'h0CFC, 4'hF, 0, 4, 32'h0BAD_F00D, 1, "R9 busy poke");
        aport(0, 16'h0CF8, 4'hF, 0, "R9 selector unchanged");
        aport(1, 16'h0CF4, 4'hF, 32'h8000_0000, "R10 foreign write");
        aport(0, 16'h0D00, 4'hF, 0, "R10 foreign read");
        aport(0, 16'h0CF8, 4'hF, 0, "R10 selector unchanged");
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule